// File: doc/BRIEF.md
# I2C Data Byte Packer

This block sits between a 16-bit software data register and a byte-wide I2C transfer engine. It stores up to four bytes in one shared buffer. A transmit fill count and a receive fill count track the buffer. Only one of the two counts is non-zero at a time. Software writes 16-bit words, or a single byte that completes a message. The engine then drains those bytes one at a time. Bytes the engine receives are collected and handed back to software in 16-bit reads.

A run-time endianness input decides where the earlier byte sits in a 16-bit word. When it is high, the earlier byte is in bits 15:8. When it is low, the earlier byte is in bits 7:0. Each data access also produces one-cycle pulses that a separate status unit uses to set or clear its flags. START/STOP generation and interrupt logic are outside this block.

Top module: `i2c_byte_packer`

## Requirements
- R1: After reset, `tx_cnt` and `rx_cnt` are 0, `tx_avail` is low and `rd_data` is 0.
- R2: An accepted 16-bit write adds two transmit bytes. With `big_end`=1 the engine receives `wr_data[15:8]` first. With `big_end`=0 it receives `wr_data[7:0]` first. `tx_byte` always shows the next byte the engine will take, and `tx_take` removes it.
- R3: Transmit bytes leave in the order they were written, across several writes, up to 4 bytes stored.
- R4: An 8-bit write (`wr_is_byte`=1, byte in `wr_data[7:0]`) is accepted only when `tx_left` equals `tx_cnt`+1. When accepted, that byte is the last one sent. Otherwise the write is dropped, `size_err` pulses and `tx_cnt` is unchanged.
- R5: A write that does not fit is dropped. It does not fit when the receive side holds data, or when the transmit side lacks room for its bytes. A dropped write pulses `xovr_fx` in that cycle and leaves `tx_cnt` unchanged.
- R6: Received bytes are stored in arrival order. A read with two or more bytes stored returns the two earliest bytes and removes them. With `big_end`=1 the earliest byte is in `rd_data[15:8]`; with `big_end`=0 it is in `rd_data[7:0]`.
- R7: A read with exactly one byte stored returns that byte in the earlier-byte half, with the other half 0. It pulses `sbd_fx` and leaves `rx_cnt` at 0.
- R8: A read of an empty receive buffer returns 0, pulses no `sbd_fx` and leaves both counts unchanged.
- R9: Every read pulses `rd_fx` (clear receive-ready and receive-overrun). A read while `mst_rx` is high also pulses `ardy_fx` (set access-ready, clear master).
- R10: Every accepted write pulses `wr_fx` (clear transmit-underflow and transmit-ready, restart the engine). A dropped write does not pulse it.
- R11: `tx_cnt` and `rx_cnt` are never both non-zero. A received byte is ignored, and `rx_room` is low, while `tx_cnt` is non-zero or 4 bytes are already received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_end | input | 1 | 1: earlier byte in upper half of the 16-bit word |
| mst_rx | input | 1 | Block is master and direction is receive |
| wr_en | input | 1 | Software data write strobe |
| wr_is_byte | input | 1 | The write is 8 bits wide |
| wr_data | input | 16 | Write data |
| tx_left | input | CW | Bytes still to be written for the current message |
| rd_en | input | 1 | Software data read strobe (takes priority over a write in the same cycle) |
| rd_data | output | 16 | Read data, valid in the read cycle |
| tx_avail | output | 1 | A transmit byte is waiting |
| tx_byte | output | 8 | Next transmit byte |
| tx_take | input | 1 | Engine takes `tx_byte` |
| rx_valid | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_room | output | 1 | A received byte would be stored |
| tx_cnt | output | 3 | Transmit fill count |
| rx_cnt | output | 3 | Receive fill count |
| wr_fx | output | 1 | Accepted-write status effect pulse |
| rd_fx | output | 1 | Read status effect pulse |
| ardy_fx | output | 1 | Master-receive read effect pulse |
| sbd_fx | output | 1 | Single-byte read pulse |
| xovr_fx | output | 1 | Dropped write (no room) pulse |
| size_err | output | 1 | Rejected byte-wide write pulse |

## Verification
The assertions check several properties on every cycle:
- The two fill counts stay within four and are never both non-zero.
- A dropped write never changes the transmit count, and an accepted write never lowers it.
- An empty read returns zero.
- A single-byte read leaves one half of the word zero.
- The master-receive pulse only appears together with the read pulse.

Only the bench scenarios can show the data itself. That covers the byte order of each endianness setting, first-in-first-out delivery across two writes, and the length rule on byte writes. It also covers received bytes being ignored while transmit data is held.

// File: rtl/i2c_byte_packer.sv
module i2c_byte_packer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          big_end,
  input  logic          mst_rx,
  input  logic          wr_en,
  input  logic          wr_is_byte,
  input  logic [15:0]   wr_data,
  input  logic [CW-1:0] tx_left,
  input  logic          rd_en,
  output logic [15:0]   rd_data,
  output logic          tx_avail,
  output logic [7:0]    tx_byte,
  input  logic          tx_take,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic          rx_room,
  output logic [2:0]    tx_cnt,
  output logic [2:0]    rx_cnt,
  output logic          wr_fx,
  output logic          rd_fx,
  output logic          ardy_fx,
  output logic          sbd_fx,
  output logic          xovr_fx,
  output logic          size_err
);
  localparam int NB = 4;
  localparam int BW = 8 * NB;

  logic [BW-1:0] dbuf, dbuf_n;
  logic [2:0]    txc, rxc, need, cons;
  logic [7:0]    b0, b1;

  wire wr_go   = wr_en && !rd_en;
  assign need  = wr_is_byte ? 3'd1 : 3'd2;
  wire room_ok = (rxc == 3'd0) && ((32'(txc) + 32'(need)) <= NB);
  wire len_ok  = !wr_is_byte || (tx_left == (CW'(txc) + CW'(1)));
  wire wr_acc  = wr_go && room_ok && len_ok;
  wire tk      = tx_take && (txc != 3'd0);

  assign rx_room = (32'(rxc) < NB) && (txc == 3'd0) && !wr_go;
  wire rx_acc  = rx_valid && rx_room;

  assign cons = !rd_en ? 3'd0 : (rxc >= 3'd2 ? 3'd2 : rxc);

  assign b0      = (rxc != 3'd0) ? dbuf[7:0]  : 8'h00;
  assign b1      = (rxc >= 3'd2) ? dbuf[15:8] : 8'h00;
  assign rd_data = big_end ? {b0, b1} : {b1, b0};

  assign tx_avail = (txc != 3'd0);
  always_comb begin
    tx_byte = 8'h00;
    for (int i = 0; i < NB; i++)
      if (32'(txc) == i + 1) tx_byte = dbuf[8*i +: 8];
  end

  always_comb begin
    dbuf_n = dbuf;
    if (wr_acc) begin
      if (wr_is_byte)
        dbuf_n = {dbuf[BW-9:0], wr_data[7:0]};
      else if (big_end)
        dbuf_n = {dbuf[BW-17:0], wr_data[15:8], wr_data[7:0]};
      else
        dbuf_n = {dbuf[BW-17:0], wr_data[7:0], wr_data[15:8]};
    end else begin
      dbuf_n = dbuf >> (8 * int'(cons));
      if (rx_acc)
        for (int i = 0; i < NB; i++)
          if (i == int'(rxc) - int'(cons)) dbuf_n[8*i +: 8] = rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbuf <= '0;
      txc  <= '0;
      rxc  <= '0;
    end else begin
      dbuf <= dbuf_n;
      txc  <= txc - {2'b00, tk} + (wr_acc ? need : 3'd0);
      rxc  <= rxc - cons + {2'b00, rx_acc};
    end
  end

  assign tx_cnt   = txc;
  assign rx_cnt   = rxc;
  assign wr_fx    = wr_acc;
  assign rd_fx    = rd_en;
  assign ardy_fx  = rd_en && mst_rx;
  assign sbd_fx   = rd_en && (rxc == 3'd1);
  assign xovr_fx  = wr_go && !room_ok;
  assign size_err = wr_go && room_ok && !len_ok;
endmodule

// File: rtl/i2c_byte_packer_chk.sv
module i2c_byte_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  tx_cnt,
  input logic [2:0]  rx_cnt,
  input logic        tx_take,
  input logic        tx_avail,
  input logic        rd_en,
  input logic [15:0] rd_data,
  input logic        sbd_fx,
  input logic        xovr_fx,
  input logic        wr_fx,
  input logic        ardy_fx,
  input logic        rd_fx
);
  // R11
  no_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_cnt != 3'd0 && rx_cnt != 3'd0));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= 3'd4 && rx_cnt <= 3'd4);

  // R5
  xovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xovr_fx |=> tx_cnt == $past(tx_cnt) - {2'b00, $past(tx_take && tx_avail)});

  // R10
  wr_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fx |=> tx_cnt >= $past(tx_cnt));

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rx_cnt == 3'd0) |-> (rd_data == 16'h0000 && !sbd_fx));

  // R7
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sbd_fx |-> (rd_data[15:8] == 8'h00 || rd_data[7:0] == 8'h00));

  // R9
  ardy_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ardy_fx |-> rd_fx);
endmodule

bind i2c_byte_packer i2c_byte_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .tx_take(tx_take), .tx_avail(tx_avail), .rd_en(rd_en), .rd_data(rd_data),
  .sbd_fx(sbd_fx), .xovr_fx(xovr_fx), .wr_fx(wr_fx), .ardy_fx(ardy_fx),
  .rd_fx(rd_fx)
);

// File: tb/i2c_byte_packer_tb.sv
`timescale 1ns/1ps
module i2c_byte_packer_tb;
  logic clk = 0, rst_n = 0;
  logic big_end = 0, mst_rx = 0, wr_en = 0, wr_is_byte = 0, rd_en = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] tx_left = '0;
  logic [15:0] rd_data;
  logic tx_avail, tx_take = 0, rx_valid = 0, rx_room;
  logic [7:0] tx_byte, rx_byte = '0;
  logic [2:0] tx_cnt, rx_cnt;
  logic wr_fx, rd_fx, ardy_fx, sbd_fx, xovr_fx, size_err;

  int checks = 0, fails = 0;
  logic s_fx, s_err, s_sbd, s_rd, s_ardy, s_room;
  logic [15:0] s_data;

  always #10 clk = ~clk;

  i2c_byte_packer u_dut (
    .clk(clk), .rst_n(rst_n), .big_end(big_end), .mst_rx(mst_rx),
    .wr_en(wr_en), .wr_is_byte(wr_is_byte), .wr_data(wr_data), .tx_left(tx_left),
    .rd_en(rd_en), .rd_data(rd_data), .tx_avail(tx_avail), .tx_byte(tx_byte),
    .tx_take(tx_take), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_room(rx_room),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .wr_fx(wr_fx), .rd_fx(rd_fx),
    .ardy_fx(ardy_fx), .sbd_fx(sbd_fx), .xovr_fx(xovr_fx), .size_err(size_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic be, input logic byt, input logic [15:0] d);
    @(negedge clk);
    big_end = be; wr_is_byte = byt; wr_data = d; wr_en = 1;
    #2 s_fx = wr_fx; s_err = size_err; s_ardy = xovr_fx;
    @(negedge clk);
    wr_en = 0; wr_is_byte = 0;
  endtask

  task automatic do_read(input logic be);
    @(negedge clk);
    big_end = be; rd_en = 1;
    #2 s_data = rd_data; s_sbd = sbd_fx; s_rd = rd_fx; s_ardy = ardy_fx;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic do_rx(input logic [7:0] b);
    @(negedge clk);
    rx_byte = b; rx_valid = 1;
    #2 s_room = rx_room;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic do_take(output logic [7:0] b);
    @(negedge clk);
    b = tx_byte; tx_take = 1;
    @(negedge clk);
    tx_take = 0;
  endtask

  // {big_end, word, first byte out, second byte out}
  localparam logic [32:0] VEC [6] = '{
    {1'b1, 16'hA1B2, 8'hA1, 8'hB2},
    {1'b0, 16'hA1B2, 8'hB2, 8'hA1},
    {1'b1, 16'h00FF, 8'h00, 8'hFF},
    {1'b0, 16'h00FF, 8'hFF, 8'h00},
    {1'b1, 16'h5A3C, 8'h5A, 8'h3C},
    {1'b0, 16'hC381, 8'h81, 8'hC3}
  };

  initial begin
    #(20 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 tx_cnt", tx_cnt, 0);
    chk("R1 rx_cnt", rx_cnt, 0);
    chk("R1 tx_avail", tx_avail, 0);
    chk("R1 rd_data", rd_data, 0);
    rst_n = 1;

    for (int i = 0; i < 6; i++) begin
      do_write(VEC[i][32], 1'b0, VEC[i][31:16]);
      chk("R10 wr_fx", s_fx, 1);
      chk("R2 tx_cnt", tx_cnt, 2);
      do_take(b);
      chk("R2 first", b, VEC[i][15:8]);
      do_take(b);
      chk("R2 second", b, VEC[i][7:0]);
      chk("R2 drained", tx_cnt, 0);
    end

    // R3 two words leave in write order
    do_write(1'b1, 1'b0, 16'h1122);
    do_write(1'b1, 1'b0, 16'h3344);
    chk("R3 full", tx_cnt, 4);
    // R5 no room
    do_write(1'b1, 1'b0, 16'hDEAD);
    chk("R5 xovr_fx", s_ardy, 1);
    chk("R10 no wr_fx on drop", s_fx, 0);
    chk("R5 tx_cnt kept", tx_cnt, 4);
    do_take(b); chk("R3 byte0", b, 8'h11);
    do_take(b); chk("R3 byte1", b, 8'h22);
    do_take(b); chk("R3 byte2", b, 8'h33);
    do_take(b); chk("R3 byte3", b, 8'h44);

    // R4 byte write rules
    tx_left = 16'd4;
    do_write(1'b1, 1'b1, 16'h00EE);
    chk("R4 size_err", s_err, 1);
    chk("R4 dropped", tx_cnt, 0);
    do_write(1'b1, 1'b0, 16'hAABB);
    tx_left = 16'd3;
    do_write(1'b1, 1'b1, 16'h00CC);
    chk("R4 accepted", s_err, 0);
    chk("R4 tx_cnt", tx_cnt, 3);
    do_take(b); chk("R4 b0", b, 8'hAA);
    do_take(b); chk("R4 b1", b, 8'hBB);
    do_take(b); chk("R4 last", b, 8'hCC);

    // R6 / R7 receive path
    do_rx(8'h10); do_rx(8'h20); do_rx(8'h30);
    chk("R6 rx_cnt", rx_cnt, 3);
    do_read(1'b1);
    chk("R6 be read", s_data, 16'h1020);
    chk("R9 rd_fx", s_rd, 1);
    chk("R9 no ardy", s_ardy, 0);
    chk("R6 rx_cnt after", rx_cnt, 1);
    do_read(1'b0);
    chk("R7 le single", s_data, 16'h0030);
    chk("R7 sbd", s_sbd, 1);
    chk("R7 rx_cnt", rx_cnt, 0);
    do_rx(8'h40);
    do_read(1'b1);
    chk("R7 be single", s_data, 16'h4000);
    do_rx(8'h01); do_rx(8'h02);
    mst_rx = 1;
    do_read(1'b0);
    chk("R6 le read", s_data, 16'h0201);
    chk("R9 ardy", s_ardy, 1);
    chk("R7 no sbd on pair", s_sbd, 0);
    mst_rx = 0;

    // R8 empty read
    do_read(1'b1);
    chk("R8 data", s_data, 0);
    chk("R8 sbd", s_sbd, 0);
    chk("R8 rx_cnt", rx_cnt, 0);
    chk("R8 tx_cnt", tx_cnt, 0);

    // R11 rx ignored during transmit, and when full
    do_write(1'b0, 1'b0, 16'h7788);
    do_rx(8'h55);
    chk("R11 rx_room", s_room, 0);
    chk("R11 rx_cnt", rx_cnt, 0);
    do_take(b); chk("R11 tx intact", b, 8'h88);
    do_take(b); chk("R11 tx intact2", b, 8'h77);
    do_rx(8'hA0); do_rx(8'hA1); do_rx(8'hA2); do_rx(8'hA3);
    do_rx(8'hA4);
    chk("R11 full room", s_room, 0);
    chk("R11 full cnt", rx_cnt, 4);
    do_write(1'b1, 1'b0, 16'h1234);
    chk("R5 write with rx data", s_ardy, 1);
    chk("R5 tx_cnt", tx_cnt, 0);
    do_read(1'b1); chk("R11 first pair", s_data, 16'hA0A1);
    do_read(1'b1); chk("R11 second pair", s_data, 16'hA2A3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule